// File: doc/BRIEF.md
# Voice Sample Concealment Buffer

This block sits between a packet-side producer that hands over received voice samples and a codec-side consumer that takes one sample per frame. Each voice channel has its own small queue. The producer tags every sample with a channel number. The consumer asks for a sample of a given channel and gets a word back one cycle later, together with a flag that says whether the word is real data or a stand-in.

When the consumer asks and the queue is empty, for example because a packet was lost, the block makes up a sample instead of stalling. Each channel picks its own stand-in policy. It can replay the most recent real sample. It can output a programmed filler word, such as a silence code. For channels marked as carrying samples wider than 24 bits, the replay policy repeats only the final byte of that sample.

When the producer runs ahead of the consumer and a queue is full, a per-channel policy decides what happens. Either the oldest unsent sample is thrown away to make room for the new one, or the new sample is discarded. Each channel keeps a saturating count of these overflow events and a flag showing whether its latest read had to be concealed.

Top module: `voice_conceal_buf`

## Requirements
- R1: After a synchronous active-low reset, every channel reports empty and not full, all overflow counts are zero, all underrun flags are clear, `rd_valid` is low, and the remembered last sample of every channel is zero.
- R2: A read of a non-empty channel returns that channel's oldest stored sample on `rd_data` in the cycle after `rd_req`, with `rd_valid`=1 and `rd_fresh`=1. Samples leave a channel in the order they were written, independently of other channels.
- R3: `chan_full[c]` and `chan_empty[c]` are registered and reflect the occupancy after the clock edge that performed the write or read. Full means DEPTH samples are held, and full and empty are never both set.
- R4: In replay mode (`cfg_repeat[c]`=1) with `cfg_wide[c]`=0, a read of an empty channel returns, with `rd_fresh`=0, the last real sample read from that channel, or zero if there has been none since reset. Concealed reads do not change the remembered sample.
- R5: In replay mode with `cfg_wide[c]`=1, a read of an empty channel returns the low byte (bits 7:0) of the remembered sample copied into every byte lane of `rd_data`, with `rd_fresh`=0.
- R6: In filler mode (`cfg_repeat[c]`=0), a read of an empty channel returns the 24-bit field `cfg_filler[c*24 +: 24]` in the low bits of `rd_data`, zero-extended, with `rd_fresh`=0.
- R7: The concealment mode and the overflow policy of one channel have no effect on the data returned from another channel.
- R8: With `cfg_allow_ovf[c]`=1, a write into a full channel without a same-cycle read of it discards the oldest held sample and stores the new one. The channel stays full.
- R9: With `cfg_allow_ovf[c]`=0, a write into a full channel without a same-cycle read of it is discarded. Content and full flag are unchanged.
- R10: Each write into a full channel without a same-cycle read of it, under either policy, adds one to `ovf_count[c*OVF_W +: OVF_W]`. The count saturates at all ones.
- R11: `underrun[c]` is set by a concealed read of channel c and cleared by a real read of channel c.
- R12: A write and a read of the same full channel in one cycle both take effect: the oldest sample is returned as real data, the new sample is stored, the channel stays full, and no overflow is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_repeat | input | NUM_CH | Per channel: 1 replay last sample, 0 output filler |
| cfg_wide | input | NUM_CH | Per channel: 1 when samples are wider than 24 bits |
| cfg_allow_ovf | input | NUM_CH | Per channel: 1 overwrite oldest when full, 0 discard new |
| cfg_filler | input | NUM_CH*24 | Per-channel filler word, channel c at bits c*24 +: 24 |
| wr_valid | input | 1 | Producer presents a sample this cycle |
| wr_ch | input | CH_W | Channel of the written sample |
| wr_data | input | SAMPLE_W | Written sample |
| rd_req | input | 1 | Consumer requests one sample |
| rd_ch | input | CH_W | Channel requested |
| rd_valid | output | 1 | `rd_data` holds the answer to last cycle's request |
| rd_data | output | SAMPLE_W | Returned sample, real or concealed |
| rd_fresh | output | 1 | 1 for real data, 0 for a concealed word |
| chan_full | output | NUM_CH | Registered full flag per channel |
| chan_empty | output | NUM_CH | Registered empty flag per channel |
| underrun | output | NUM_CH | Per channel: last read was concealed |
| ovf_count | output | NUM_CH*OVF_W | Saturating overflow event counts, channel c at c*OVF_W +: OVF_W |

## Verification
Two situations are hard to reach from the ports. The first is the wide-sample replay path, which needs a channel that has delivered real data, is then drained, and is read again with the wide flag set. The bench reaches it by sweeping every combination of replay or filler, overwrite or discard, and narrow or wide on each channel. Each sweep round overfills the queue by two and then reads two past the end, while the other channel is set to the opposite settings.

The second is the saturated overflow count, together with a same-cycle write and read on a full channel. The bench reaches the count by holding a full channel and writing into it more times than the counter can count. It reaches the same-cycle case by issuing the write and the read in one cycle on a full queue.

// File: rtl/vcb_pkg.sv
// Package: shared constants and types for the voice concealment buffer.
// Assumes sample words are a whole number of bytes and at least 24 bits wide.
package vcb_pkg;
    // Width of the per-channel filler word.
    localparam int FILL_W = 24;

    // Source of the word returned to the reader.
    typedef enum logic [1:0] {
        SRC_QUEUE = 2'd0,   // real sample from the channel queue
        SRC_LAST  = 2'd1,   // replay of the remembered sample
        SRC_BYTE  = 2'd2,   // low byte of remembered sample in every lane
        SRC_FILL  = 2'd3    // programmed filler, zero-extended
    } src_t;
endpackage

// File: rtl/vcb_chan_store.sv
// Module: one channel's sample queue with overflow policy and event counter.
// Holds up to DEPTH samples in a circular store. A write into a full queue
// with no same-cycle pop either evicts the oldest sample (allow_ovf=1) or is
// dropped (allow_ovf=0). Either way it counts as an overflow event.
// Assumes pop_req is only acted on when the queue is not empty.
module vcb_chan_store #(
    parameter int DEPTH    = 4,
    parameter int SAMPLE_W = 32,
    parameter int OVF_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                pop_req,
    input  logic                allow_ovf,
    output logic [SAMPLE_W-1:0] head,
    output logic                full,
    output logic                empty,
    output logic [OVF_W-1:0]    ovf_count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [OVF_W-1:0] OVF_MAX  = '1;

    logic [SAMPLE_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0]    level, level_nxt;
    logic                pop, ovf_evt, do_push, do_adv, grow;

    // Decide this cycle's pop, push, eviction and overflow event.
    always_comb begin
        pop       = pop_req && !empty;
        ovf_evt   = wr_en && full && !pop;
        do_push   = wr_en && (!full || pop || allow_ovf);
        do_adv    = pop || (ovf_evt && allow_ovf);
        grow      = do_push && !ovf_evt;
        level_nxt = level;
        if (grow && !pop)      level_nxt = level + 1'b1;
        else if (!grow && pop) level_nxt = level - 1'b1;
    end

    // Sample storage; written at the write pointer, not reset.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= wr_data;
    end

    // Pointers, occupancy and registered full/empty flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_adv)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            level <= level_nxt;
            full  <= (level_nxt == CNT_FULL);
            empty <= (level_nxt == '0);
        end
    end

    // Saturating count of overflow events.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf_count <= '0;
        else if (ovf_evt && ovf_count != OVF_MAX) ovf_count <= ovf_count + 1'b1;
    end

    assign head = store[rd_ptr];

    // R3: flags are never both set.
    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R9: a dropped write leaves the queue full with the same head.
    p_drop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop_req && !allow_ovf) |=> (full && head == $past(head)));

    // R8: an overwriting write leaves the queue full.
    p_overwrite_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop_req && allow_ovf) |=> full);

    // R10: each overflow event adds one below saturation.
    p_ovf_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop_req && ovf_count != OVF_MAX)
        |=> (ovf_count == $past(ovf_count) + 1'b1));

    // R10: a saturated count stays saturated.
    p_ovf_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count == OVF_MAX) |=> (ovf_count == OVF_MAX));

    // R12: same-cycle read and write on a full queue keeps it full, no count.
    p_pass_through_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && pop_req) |=> (full && $stable(ovf_count)));
endmodule

// File: rtl/vcb_conceal.sv
// Module: read-side selection and loss concealment for all channels.
// Returns the head of the requested channel, or a stand-in word when that
// channel is empty, one cycle after the request. Remembers the last real
// sample per channel and keeps a per-channel underrun flag.
// Assumes rd_ch < NUM_CH, SAMPLE_W >= FILL_W and SAMPLE_W a multiple of 8.
module vcb_conceal
    import vcb_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int SAMPLE_W = 32,
    parameter int CH_W     = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_req,
    input  logic [CH_W-1:0]            rd_ch,
    input  logic [NUM_CH*SAMPLE_W-1:0] head_flat,
    input  logic [NUM_CH-1:0]          empty_vec,
    input  logic [NUM_CH-1:0]          cfg_repeat,
    input  logic [NUM_CH-1:0]          cfg_wide,
    input  logic [NUM_CH*FILL_W-1:0]   cfg_filler,
    output logic                       rd_valid,
    output logic [SAMPLE_W-1:0]        rd_data,
    output logic                       rd_fresh,
    output logic [NUM_CH-1:0]          underrun
);
    localparam int LANES = SAMPLE_W / 8;

    logic [SAMPLE_W-1:0] heads  [NUM_CH];
    logic [FILL_W-1:0]   fills  [NUM_CH];
    logic [SAMPLE_W-1:0] last_q [NUM_CH];
    logic [SAMPLE_W-1:0] sel_head, sel_last, out_word;
    logic                sel_empty;
    src_t                src;

    // Unpack the flat per-channel buses.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
        assign heads[c] = head_flat[c*SAMPLE_W +: SAMPLE_W];
        assign fills[c] = cfg_filler[c*FILL_W +: FILL_W];
    end

    // Pick the source for the requested channel and form the word.
    always_comb begin
        sel_head  = heads[rd_ch];
        sel_last  = last_q[rd_ch];
        sel_empty = empty_vec[rd_ch];
        if (!sel_empty)              src = SRC_QUEUE;
        else if (!cfg_repeat[rd_ch]) src = SRC_FILL;
        else if (cfg_wide[rd_ch])    src = SRC_BYTE;
        else                         src = SRC_LAST;
        unique case (src)
            SRC_QUEUE: out_word = sel_head;
            SRC_LAST:  out_word = sel_last;
            SRC_BYTE:  out_word = {LANES{sel_last[7:0]}};
            SRC_FILL:  out_word = SAMPLE_W'(fills[rd_ch]);
            default:   out_word = '0;
        endcase
    end

    // Register the answer, remember real samples, track underruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_fresh <= 1'b0;
            underrun <= '0;
            for (int c = 0; c < NUM_CH; c++) last_q[c] <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data         <= out_word;
                rd_fresh        <= !sel_empty;
                underrun[rd_ch] <= sel_empty;
                if (!sel_empty) last_q[rd_ch] <= sel_head;
            end
        end
    end

    // R1/R2: an answer only follows a request.
    p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R2: a read of a non-empty channel returns its head as real data.
    p_fresh_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !empty_vec[rd_ch]) |=> (rd_fresh && rd_data == $past(sel_head)));

    // R4: a read of an empty channel is always marked concealed.
    p_conceal_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty_vec[rd_ch]) |=> (rd_valid && !rd_fresh));

    // R11: at most one channel's underrun flag changes per cycle.
    p_underrun_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(underrun ^ $past(underrun)) <= 1);
endmodule

// File: rtl/voice_conceal_buf.sv
// Module: top of the voice sample concealment buffer.
// One queue per channel, write and read demultiplexed by channel number,
// and a shared concealment stage on the read side.
// Assumes wr_ch and rd_ch are below NUM_CH and NUM_CH >= 2.
module voice_conceal_buf
    import vcb_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int DEPTH    = 4,
    parameter int SAMPLE_W = 32,
    parameter int OVF_W    = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        cfg_repeat,
    input  logic [NUM_CH-1:0]        cfg_wide,
    input  logic [NUM_CH-1:0]        cfg_allow_ovf,
    input  logic [NUM_CH*FILL_W-1:0] cfg_filler,
    input  logic                     wr_valid,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [SAMPLE_W-1:0]      wr_data,
    input  logic                     rd_req,
    input  logic [CH_W-1:0]          rd_ch,
    output logic                     rd_valid,
    output logic [SAMPLE_W-1:0]      rd_data,
    output logic                     rd_fresh,
    output logic [NUM_CH-1:0]        chan_full,
    output logic [NUM_CH-1:0]        chan_empty,
    output logic [NUM_CH-1:0]        underrun,
    output logic [NUM_CH*OVF_W-1:0]  ovf_count
);
    logic [NUM_CH-1:0]          wr_sel, pop_sel;
    logic [NUM_CH*SAMPLE_W-1:0] head_flat;

    // One queue per channel, selected by the channel number.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign wr_sel[c]  = wr_valid && (wr_ch == CH_W'(c));
        assign pop_sel[c] = rd_req && (rd_ch == CH_W'(c));

        vcb_chan_store #(
            .DEPTH    (DEPTH),
            .SAMPLE_W (SAMPLE_W),
            .OVF_W    (OVF_W)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_sel[c]),
            .wr_data   (wr_data),
            .pop_req   (pop_sel[c]),
            .allow_ovf (cfg_allow_ovf[c]),
            .head      (head_flat[c*SAMPLE_W +: SAMPLE_W]),
            .full      (chan_full[c]),
            .empty     (chan_empty[c]),
            .ovf_count (ovf_count[c*OVF_W +: OVF_W])
        );
    end

    vcb_conceal #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .CH_W     (CH_W)
    ) u_conceal (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rd_ch      (rd_ch),
        .head_flat  (head_flat),
        .empty_vec  (chan_empty),
        .cfg_repeat (cfg_repeat),
        .cfg_wide   (cfg_wide),
        .cfg_filler (cfg_filler),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_fresh   (rd_fresh),
        .underrun   (underrun)
    );

    // R1: no answer without a request after reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(rd_req));
endmodule

// File: tb/voice_conceal_buf_test.sv
`timescale 1ns/100ps
module voice_conceal_buf_test;
    localparam int NCH = 2;
    localparam int DEP = 4;
    localparam int SW  = 32;
    localparam int OW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  cfg_repeat = '0, cfg_wide = '0, cfg_allow_ovf = '0;
    logic [NCH*24-1:0] cfg_filler = '0;
    logic            wr_valid = 1'b0;
    logic [0:0]      wr_ch = '0;
    logic [SW-1:0]   wr_data = '0;
    logic            rd_req = 1'b0;
    logic [0:0]      rd_ch = '0;
    logic            rd_valid, rd_fresh;
    logic [SW-1:0]   rd_data;
    logic [NCH-1:0]  chan_full, chan_empty, underrun;
    logic [NCH*OW-1:0] ovf_count;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_ovf [NCH];

    always #2.5 clk = ~clk;

    voice_conceal_buf #(.NUM_CH(NCH), .DEPTH(DEP), .SAMPLE_W(SW), .OVF_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_repeat(cfg_repeat), .cfg_wide(cfg_wide),
        .cfg_allow_ovf(cfg_allow_ovf), .cfg_filler(cfg_filler),
        .wr_valid(wr_valid), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_req(rd_req), .rd_ch(rd_ch), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_fresh(rd_fresh), .chan_full(chan_full), .chan_empty(chan_empty),
        .underrun(underrun), .ovf_count(ovf_count));

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] samp(int ch, int rnd, int i);
        return {8'(8'h80 + i), 8'(rnd), 8'(ch), 8'(8'h31 + 16*i)};
    endfunction

    task automatic do_write(int ch, logic [SW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_ch = 1'(ch); wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic do_read(int ch, logic [SW-1:0] exp_d, logic exp_f, string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_ch = 1'(ch);
        @(posedge clk); #1;
        rd_req = 1'b0;
        check(rd_valid && rd_fresh == exp_f && rd_data == exp_d, tag,
              {31'd0, rd_valid, rd_fresh, rd_data}, {32'd1, exp_f, exp_d});
    endtask

    task automatic do_wr_rd(int ch, logic [SW-1:0] d, logic [SW-1:0] exp_d, string tag);
        @(negedge clk);
        wr_valid = 1'b1; wr_ch = 1'(ch); wr_data = d;
        rd_req = 1'b1; rd_ch = 1'(ch);
        @(posedge clk); #1;
        wr_valid = 1'b0; rd_req = 1'b0;
        check(rd_valid && rd_fresh && rd_data == exp_d, tag,
              {31'd0, rd_valid, rd_fresh, rd_data}, {32'd1, 1'b1, exp_d});
    endtask

    task automatic check_ovf(int ch, string tag);
        check(ovf_count[ch*OW +: OW] == OW'(exp_ovf[ch]), tag,
              64'(ovf_count[ch*OW +: OW]), 64'(exp_ovf[ch]));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : main
        logic [SW-1:0] last_fresh, exp_c;
        cfg_filler = {24'h00C3F0, 24'h5A5A5A};
        for (int c = 0; c < NCH; c++) exp_ovf[c] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state.
        check(chan_empty == 2'b11 && chan_full == 2'b00 && ovf_count == '0 &&
              underrun == 2'b00 && !rd_valid, "R1 reset state",
              {44'd0, chan_empty, chan_full, ovf_count, underrun, rd_valid},
              {44'd0, 2'b11, 2'b00, 16'd0, 2'b00, 1'b0});

        // R4: replay before any real sample gives zero.
        cfg_repeat = 2'b11; cfg_wide = 2'b00;
        do_read(1, '0, 1'b0, "R4 replay with no history is zero");
        check(underrun[1] == 1'b1, "R11 underrun set on concealed read", 64'(underrun), 64'd2);

        // Sweep: channel x replay/filler x overwrite/drop x narrow/wide.
        for (int ch = 0; ch < NCH; ch++) begin
            for (int m = 0; m < 4; m++) begin
                for (int w = 0; w < 2; w++) begin
                    automatic int rnd = ch*8 + m*2 + w;
                    automatic logic rep = m[0];
                    automatic logic alw = m[1];
                    // R7: the other channel gets opposite settings.
                    cfg_repeat    = ch ? {rep, !rep} : {!rep, rep};
                    cfg_allow_ovf = ch ? {alw, !alw} : {!alw, alw};
                    cfg_wide      = ch ? {1'(w), !1'(w)} : {!1'(w), 1'(w)};
                    for (int i = 0; i < DEP + 2; i++) do_write(ch, samp(ch, rnd, i));
                    exp_ovf[ch] += 2;
                    check(chan_full[ch] && !chan_empty[ch], "R3 full after overfill",
                          {62'd0, chan_full[ch], chan_empty[ch]}, 64'd2);
                    check_ovf(ch, "R10 two overflow events per round");
                    check(chan_empty[1-ch] && ovf_count[(1-ch)*OW +: OW] == OW'(exp_ovf[1-ch]),
                          "R7 other channel untouched", 64'(ovf_count), 64'(exp_ovf[1-ch]));
                    for (int j = 0; j < DEP; j++) begin
                        automatic int idx = alw ? j + 2 : j;
                        do_read(ch, samp(ch, rnd, idx), 1'b1,
                                alw ? "R8 overwrite keeps newest in order" : "R9 drop keeps oldest in order");
                        if (j == 0)
                            check(underrun[ch] == 1'b0, "R11 underrun cleared by real read",
                                  64'(underrun[ch]), 64'd0);
                    end
                    check(chan_empty[ch] && !chan_full[ch], "R3 empty after drain",
                          {62'd0, chan_full[ch], chan_empty[ch]}, 64'd1);
                    last_fresh = samp(ch, rnd, alw ? DEP + 1 : DEP - 1);
                    if (!rep)   exp_c = {8'd0, cfg_filler[ch*24 +: 24]};
                    else if (w) exp_c = {4{last_fresh[7:0]}};
                    else        exp_c = last_fresh;
                    for (int k = 0; k < 2; k++)
                        do_read(ch, exp_c, 1'b0,
                                !rep ? "R6 filler on empty" : (w ? "R5 wide replays low byte" : "R4 replay last sample"));
                    check(underrun[ch] == 1'b1, "R11 underrun after concealment",
                          64'(underrun[ch]), 64'd1);
                end
            end
        end

        // R12: write and read together on a full channel.
        cfg_allow_ovf = 2'b00; cfg_repeat = 2'b11; cfg_wide = 2'b00;
        for (int i = 0; i < DEP; i++) do_write(0, samp(0, 99, i));
        do_wr_rd(0, samp(0, 99, 7), samp(0, 99, 0), "R12 same-cycle read returns oldest");
        check(chan_full[0], "R12 stays full", 64'(chan_full), 64'd1);
        check_ovf(0, "R12 no overflow counted");
        for (int i = 1; i < DEP; i++) do_read(0, samp(0, 99, i), 1'b1, "R12 order kept");
        do_read(0, samp(0, 99, 7), 1'b1, "R12 new sample stored last");

        // R10: saturation of the overflow counter.
        for (int i = 0; i < DEP; i++) do_write(0, samp(0, 77, i));
        for (int i = 0; i < 260; i++) do_write(0, 32'hDEAD0000 + 32'(i));
        exp_ovf[0] = 255;
        check_ovf(0, "R10 counter saturates");
        for (int i = 0; i < DEP; i++) do_read(0, samp(0, 77, i), 1'b1, "R9 content kept under repeated drops");

        summary();
        $finish;
    end
endmodule